// File: doc/BRIEF.md
# Isolated I/O Bus Cycle Sequencer

This block runs one minimum-mode bus cycle to a 16-bit isolated I/O port space over a multiplexed address/data bus. A host raises a request with a direction flag, a size flag, a port number and write data. The block then steps through four bus states, one clock each: T1, T2, T3 and T4. It drives the memory/IO select line, an address latch enable pulse, the 20 multiplexed address/data lines with their output enable, a data enable strobe, and read and write strobes. On a read it returns the byte it sampled from the bus.

The data path is 8 bits wide. A 16-bit transfer is carried out as two back-to-back byte cycles. The low byte goes first at the requested port and the high byte follows at the next port number, with the port number wrapping within 16 bits. While a transfer runs, the block ignores new requests and holds a busy flag. It pulses done in the final T4.

Top module: `io_cycle_seq`

## Requirements
- R1: In T1 the port number appears on ad_o[15:0] with bit 0 least significant, ad_oe_o is 1, and ale_o is 1. ale_o is 0 in every other state.
- R2: ad_o[19:16] is 0 in every cycle, including the T1 address period.
- R3: io_sel_o is 1 (I/O level) from T1 through T4 of every byte cycle and 0 while idle.
- R4: An accepted request (req_i high while idle) puts the block in T1 on the next clock. The states then advance T1, T2, T3, T4, one per clock.
- R5: On a read (req_wr_i=0), den_n_o and rd_n_o are 0 in T2 and T3 and 1 otherwise. ad_oe_o is 0 from T2 to T4. The byte on ad_i is sampled at the end of T3.
- R6: On a write (req_wr_i=1), the write byte is driven on ad_o[7:0] with ad_oe_o=1 from T2 through T4. wr_n_o and den_n_o are 0 in T2 and T3 and 1 otherwise.
- R7: All three strobes (den_n_o, rd_n_o, wr_n_o) are 1 in T4 and while idle, and rd_n_o and wr_n_o are never 0 together.
- R8: busy_o is 1 from the clock after acceptance until the final T4 ends. done_o is 1 for exactly the final T4 of a transfer.
- R9: With req_word_i=1, a second full byte cycle follows the first at port+1 (modulo 2^16), using req_wdata_i[15:8] for writes and capturing into rdata_o[15:8] for reads. A byte read sets rdata_o[7:0] to the sampled byte and rdata_o[15:8] to 0, and rdata_o holds its value between captures. After reset it is 0.
- R10: A request raised while busy_o is 1 is ignored: it changes neither the port, the data nor the length of the running transfer, and it starts no cycle afterwards unless it is still high when the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Transfer request |
| req_wr_i | input | 1 | 1 = output (write), 0 = input (read) |
| req_word_i | input | 1 | 1 = 16-bit transfer as two byte cycles |
| req_addr_i | input | 16 | Port number |
| req_wdata_i | input | 16 | Write data, low byte first |
| ad_i | input | 8 | Data sampled from the bus |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Final T4 of the transfer |
| rdata_o | output | 16 | Read data |
| io_sel_o | output | 1 | Memory/IO select, 1 = I/O |
| ale_o | output | 1 | Address latch enable |
| ad_o | output | 20 | Multiplexed address/data out |
| ad_oe_o | output | 1 | Drive enable for ad_o |
| den_n_o | output | 1 | Data enable, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |

## Verification
The bench builds the block with its default parameters: a 16-bit port space, a 20-line bus and an 8-bit data path. With these values the top four lines must stay at zero, and a word transfer at port 0xFFFF wraps its second byte to port 0x0000. The reference model predicts every pin in every cycle. This covers byte and word transfers in both directions, requests held high back to back, and requests that arrive mid-transfer.

// File: rtl/io_seq_pkg.sv
package io_seq_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_T1, PH_T2, PH_T3, PH_T4} phase_t;
endpackage

// File: rtl/io_seq_ctrl.sv
module io_seq_ctrl
  import io_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_i,
  input  logic   word_i,
  output phase_t phase_o,
  output logic   beat_o,
  output logic   accept_o,
  output logic   busy_o,
  output logic   done_o
);
  phase_t ph_q, ph_d;
  logic   beat_q, beat_d;
  logic   more;

  assign more = word_i && !beat_q;

  always_comb begin
    ph_d     = ph_q;
    beat_d   = beat_q;
    accept_o = 1'b0;
    case (ph_q)
      PH_IDLE: if (req_i) begin
        accept_o = 1'b1;
        ph_d     = PH_T1;
        beat_d   = 1'b0;
      end
      PH_T1: ph_d = PH_T2;
      PH_T2: ph_d = PH_T3;
      PH_T3: ph_d = PH_T4;
      PH_T4: if (more) begin
        ph_d   = PH_T1;
        beat_d = 1'b1;
      end else begin
        ph_d = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      beat_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      beat_q <= beat_d;
    end
  end

  assign phase_o = ph_q;
  assign beat_o  = beat_q;
  assign busy_o  = (ph_q != PH_IDLE);
  assign done_o  = (ph_q == PH_T4) && !more;

  // R4: acceptance leads straight into T1
  assert_accept_t1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> (phase_o == PH_T1) && busy_o);
  // R8: the done pulse is followed by idle
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o && !done_o);
  // R10: no acceptance while busy
  assert_no_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !accept_o);
endmodule

// File: rtl/io_seq_capture.sv
module io_seq_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              beat_i,
  input  logic              word_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [2*DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (en_i) begin
      if (beat_i) begin
        hi_q <= din_i;
      end else begin
        lo_q <= din_i;
        if (!word_i) hi_q <= '0;
      end
    end
  end

  assign rdata_o = {hi_q, lo_q};

  // R9: read data only moves on a capture
  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(rdata_o));
endmodule

// File: rtl/io_seq_drive.sv
module io_seq_drive
  import io_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BUS_W  = 20,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  phase_t              phase_i,
  input  logic                beat_i,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [2*DATA_W-1:0] wdata_i,
  output logic                io_sel_o,
  output logic                ale_o,
  output logic [BUS_W-1:0]    ad_o,
  output logic                ad_oe_o,
  output logic                den_n_o,
  output logic                rd_n_o,
  output logic                wr_n_o
);
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_byte;
  logic              strobe_win;
  logic              data_win;

  assign cur_addr   = addr_i + ADDR_W'(beat_i);
  assign cur_byte   = beat_i ? wdata_i[2*DATA_W-1:DATA_W] : wdata_i[DATA_W-1:0];
  assign strobe_win = (phase_i == PH_T2) || (phase_i == PH_T3);
  assign data_win   = strobe_win || (phase_i == PH_T4);

  always_comb begin
    ad_o    = '0;
    ad_oe_o = 1'b0;
    if (phase_i == PH_T1) begin
      ad_o[ADDR_W-1:0] = cur_addr;
      ad_oe_o          = 1'b1;
    end else if (wr_i && data_win) begin
      ad_o[DATA_W-1:0] = cur_byte;
      ad_oe_o          = 1'b1;
    end
  end

  assign io_sel_o = (phase_i != PH_IDLE);
  assign ale_o    = (phase_i == PH_T1);
  assign den_n_o  = !strobe_win;
  assign rd_n_o   = !(strobe_win && !wr_i);
  assign wr_n_o   = !(strobe_win && wr_i);

  // R2: upper lines stay low while the address is latched
  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |-> (ad_o[BUS_W-1:ADDR_W] == '0));
  // R1: the latch pulse lasts one clock
  assert_ale_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |=> !ale_o && io_sel_o);
  // R7: read and write strobes never overlap
  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n_o && !wr_n_o));
  // R6: write data stays put while the write strobe is low
  assert_wdata_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n_o |=> wr_n_o || $stable(ad_o));
endmodule

// File: rtl/io_cycle_seq.sv
module io_cycle_seq
  import io_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BUS_W  = 20,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_i,
  input  logic                req_wr_i,
  input  logic                req_word_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [2*DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0]   ad_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [2*DATA_W-1:0] rdata_o,
  output logic                io_sel_o,
  output logic                ale_o,
  output logic [BUS_W-1:0]    ad_o,
  output logic                ad_oe_o,
  output logic                den_n_o,
  output logic                rd_n_o,
  output logic                wr_n_o
);
  localparam int WDATA_W = 2 * DATA_W;

  phase_t             phase;
  logic               beat, accept;
  logic               wr_q, word_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [WDATA_W-1:0] wdata_q;
  logic               cap_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      word_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= req_wr_i;
      word_q  <= req_word_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end
  end

  io_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .word_i   (word_q),
    .phase_o  (phase),
    .beat_o   (beat),
    .accept_o (accept),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  assign cap_en = (phase == PH_T3) && !wr_q;

  io_seq_capture #(.DATA_W(DATA_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (cap_en),
    .beat_i  (beat),
    .word_i  (word_q),
    .din_i   (ad_i),
    .rdata_o (rdata_o)
  );

  io_seq_drive #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .DATA_W(DATA_W)) u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase_i  (phase),
    .beat_i   (beat),
    .wr_i     (wr_q),
    .addr_i   (addr_q),
    .wdata_i  (wdata_q),
    .io_sel_o (io_sel_o),
    .ale_o    (ale_o),
    .ad_o     (ad_o),
    .ad_oe_o  (ad_oe_o),
    .den_n_o  (den_n_o),
    .rd_n_o   (rd_n_o),
    .wr_n_o   (wr_n_o)
  );

  // R3: I/O select holds for the whole cycle
  assert_sel_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_sel_o && !done_o) |=> io_sel_o);
  // R10: latched transfer stays fixed while busy
  assert_latch_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> $stable(addr_q) && $stable(wdata_q) && $stable(word_q));
endmodule

// File: tb/io_cycle_seq_bench.sv
module io_cycle_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0, req_wr_i = 1'b0, req_word_i = 1'b0;
  logic [15:0] req_addr_i = '0, req_wdata_i = '0;
  logic [7:0]  ad_i = '0;
  logic        busy_o, done_o, io_sel_o, ale_o, ad_oe_o, den_n_o, rd_n_o, wr_n_o;
  logic [15:0] rdata_o;
  logic [19:0] ad_o;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  io_cycle_seq u_io_cycle_seq (.*);

  // reference model
  int          m_ph, m_beat;
  logic        m_wr, m_word;
  logic [15:0] m_addr, m_wdata, m_rdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_beat = 0; m_wr = 0; m_word = 0;
      m_addr = 0; m_wdata = 0; m_rdata = 0;
    end else begin
      cyc++;
      if (m_ph == 0) begin
        if (req_i) begin
          m_ph = 1; m_beat = 0; m_wr = req_wr_i; m_word = req_word_i;
          m_addr = req_addr_i; m_wdata = req_wdata_i;
        end
      end else if (m_ph < 4) begin
        if (m_ph == 3 && !m_wr) begin
          if (m_beat == 1) m_rdata[15:8] = ad_i;
          else begin
            m_rdata[7:0] = ad_i;
            if (!m_word) m_rdata[15:8] = 8'h00;
          end
        end
        m_ph++;
      end else begin
        if (m_word && m_beat == 0) begin m_beat = 1; m_ph = 1; end
        else m_ph = 0;
      end
    end
  end

  always @(posedge clk) begin
    #1 ad_i <= 8'h3C ^ 8'(cyc * 7);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin : cmp
      logic        sw;
      logic [15:0] ea;
      logic [7:0]  eb;
      logic [19:0] ead;
      logic        eoe;
      sw  = (m_ph == 2) || (m_ph == 3);
      ea  = m_addr + 16'(m_beat);
      eb  = m_beat ? m_wdata[15:8] : m_wdata[7:0];
      ead = '0; eoe = 1'b0;
      if (m_ph == 1) begin ead = {4'h0, ea}; eoe = 1'b1; end
      else if (m_wr && m_ph >= 2) begin ead = {12'h0, eb}; eoe = 1'b1; end
      chk("R1 ale", ale_o, m_ph == 1);
      chk("R2/R1/R6 ad_o", ad_o, ead);
      chk("R2 upper", ad_o[19:16], 0);
      chk("R5/R6 ad_oe", ad_oe_o, eoe);
      chk("R3 io_sel", io_sel_o, m_ph != 0);
      chk("R5/R6 den_n", den_n_o, !sw);
      chk("R5/R7 rd_n", rd_n_o, !(sw && !m_wr));
      chk("R6/R7 wr_n", wr_n_o, !(sw && m_wr));
      chk("R4/R8 busy", busy_o, m_ph != 0);
      chk("R8 done", done_o, m_ph == 4 && !(m_word && m_beat == 0));
      chk("R9/R5 rdata", rdata_o, m_rdata);
    end
  end

  task automatic xfer(input logic wr, input logic word, input logic [15:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    req_i = 1; req_wr_i = wr; req_word_i = word; req_addr_i = a; req_wdata_i = d;
    @(posedge clk); #1;
    req_i = 0;
    while (busy_o) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R8 reset busy", busy_o, 0);
    chk("R3 reset io_sel", io_sel_o, 0);
    chk("R7 reset strobes", {den_n_o, rd_n_o, wr_n_o}, 3'b111);
    chk("R9 reset rdata", rdata_o, 0);
    rst_n = 1;
    xfer(1, 0, 16'h0089, 16'h0034);   // R6 byte write
    xfer(0, 0, 16'h00FE, 16'h0000);   // R5 byte read
    xfer(1, 1, 16'hEA20, 16'hB0DA);   // R9 word write
    xfer(0, 1, 16'hFFFF, 16'h0000);   // R9 word read with wrap
    xfer(0, 0, 16'h1234, 16'h0000);   // R9 byte read clears high byte
    // R4 back-to-back: request held high
    @(posedge clk); #1;
    req_i = 1; req_wr_i = 1; req_word_i = 0; req_addr_i = 16'h00AA; req_wdata_i = 16'h0055;
    repeat (12) @(posedge clk);
    #1 req_i = 0;
    while (busy_o) begin @(posedge clk); #1; end
    // R10 request while busy is ignored
    @(posedge clk); #1;
    req_i = 1; req_wr_i = 0; req_word_i = 0; req_addr_i = 16'h00BA;
    @(posedge clk); #1;
    req_i = 0;
    @(posedge clk); #1;
    req_i = 1; req_wr_i = 1; req_word_i = 1; req_addr_i = 16'h7777; req_wdata_i = 16'hFFFF;
    @(posedge clk); #1;
    req_i = 0;
    repeat (4) @(posedge clk);
    #1 chk("R10 no late start", busy_o, 0);
    repeat (4) @(posedge clk);
    #1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule